// File: doc/BRIEF.md
# Constant Buffer Upload and Bind Unit

This block sits on a register write path and handles two jobs for a shader front end. The first is streaming constant data into memory. A base address, a byte size and a byte position are held in registers. Every write that lands in a window of sixteen aliased data registers becomes a single 32-bit memory write request at base plus position, and the position then moves on by one word. An upload that would run off the end of the buffer is refused, and so is one made while no buffer is set up (base of zero). In both cases an error pulse is raised in place of the request.

The second job is binding. Each of the five shader stages has its own bind trigger register. A write to it takes a snapshot of the current base address and size into a slot of that stage's table. The slot is chosen by an index field in the written word. A combinational read port returns any slot's contents, together with the stage's enable. The vertex stage is always enabled. The other four stages take their enable from a configuration register. Address translation and the memory itself sit outside the block.

Top module: `cbuf_upload_bind`

## Requirements
- R1: After reset, and again after any later reset, the block makes no memory request, raises no error pulse, every table slot reads as zero (enabled 0, index 0, address 0, size 0), and stages 1 to 4 read as disabled.
- R2: A write to any register index from 0x10 to 0x1F is a data write. When it is legal, exactly one cycle of `mem_wr_valid` follows on the next clock. In that cycle `mem_wr_addr` equals base plus position and `mem_wr_data` equals the written value.
- R3: Each accepted data write moves the position forward by 4 bytes. A write to index 0x03 loads the position directly from the data bits.
- R4: A data write where position + 4 > size produces a one-cycle `err_overrun` pulse in place of a request, and leaves the position unchanged.
- R5: A data write while the 40-bit base is zero produces a one-cycle `err_null_base` pulse in place of a request, and leaves the position unchanged.
- R6: The base is built from two writes. Index 0x01 supplies address bits 39:32 from data bits 7:0. Index 0x02 supplies address bits 31:0. Index 0x00 sets the size in bytes.
- R7: A write to index 0x20+s binds a slot for stage s, with stages ordered 0 vertex, 1 tessellation control, 2 tessellation evaluation, 3 geometry and 4 fragment. The slot number is taken from data bits 8:4. The slot stores enabled (data bit 0), that index, and the base and size current at the time of the write. Later changes to the base or size leave stored slots untouched.
- R8: A bind write whose index is 18 or more changes no slot and produces a one-cycle `err_bad_slot` pulse.
- R9: The read port is combinational over `rd_stage`/`rd_slot`. A stage of 5 or more, or a slot of 18 or more, reads all zeros.
- R10: `rd_stage_en` is always 1 for stage 0. Stages 1 to 4 follow bits 0 to 3 of the register at index 0x04. Stages of 5 or more read 0.
- R11: Writes to indices that have no function cause no request and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Register index |
| wr_data | input | 32 | Register write value |
| rd_stage | input | 3 | Stage selected for table read |
| rd_slot | input | 5 | Slot selected for table read |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_addr | output | 40 | Request byte address |
| mem_wr_data | output | 32 | Request data word |
| err_overrun | output | 1 | Data write past the buffer end refused |
| err_null_base | output | 1 | Data write with zero base refused |
| err_bad_slot | output | 1 | Bind index out of range ignored |
| rd_enabled | output | 1 | Slot enabled flag |
| rd_index | output | 5 | Slot stored index |
| rd_addr | output | 40 | Slot stored buffer address |
| rd_size | output | 32 | Slot stored buffer size |
| rd_stage_en | output | 1 | Stage enable |

## Verification
The bench runs all sixteen data-window aliases in one run of uploads. A design that decoded only part of the window, or that failed to advance, would give wrong request addresses. It probes the end of the buffer at exactly size − 4, at size, and with a size of zero or two bytes. An off-by-one bound check would either drop the last word or write one word past the end. After each refused write it checks that a later legal write lands at the old position, which catches a design that advances on error. The bind test covers every index of every stage and checks that an out-of-range index leaves the aliased low slot intact. It also checks that a later base change does not leak into stored slots, that all sixteen enable patterns map to the right stages, and that a second reset clears the table.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

   // register index map (8-bit index space)
   localparam logic [7:0] IDX_SIZE       = 8'h00;
   localparam logic [7:0] IDX_BASE_HI    = 8'h01;
   localparam logic [7:0] IDX_BASE_LO    = 8'h02;
   localparam logic [7:0] IDX_POS        = 8'h03;
   localparam logic [7:0] IDX_STAGE_EN   = 8'h04;
   localparam int         IDX_DATA_FIRST = 16'h10;
   localparam int         IDX_BIND_FIRST = 16'h20;

   // bind word layout
   localparam int BIND_VALID_BIT = 0;
   localparam int BIND_SLOT_LSB  = 4;

   // byte step of one uploaded word
   localparam int WORD_BYTES = 4;

   typedef enum logic [2:0] {
      STG_VERTEX    = 3'd0,
      STG_TESS_CTRL = 3'd1,
      STG_TESS_EVAL = 3'd2,
      STG_GEOMETRY  = 3'd3,
      STG_FRAGMENT  = 3'd4
   } stage_e;

endpackage

// File: rtl/cbuf_cfg_regs.sv
module cbuf_cfg_regs #(
   parameter int ADDR_W    = 40,
   parameter int DATA_W    = 32,
   parameter int SIZE_W    = 32,
   parameter int REG_IDX_W = 8,
   parameter int NUM_PROG  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_IDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 advance,
   output logic [ADDR_W-1:0]    base_o,
   output logic [SIZE_W-1:0]    size_o,
   output logic [SIZE_W-1:0]    pos_o,
   output logic [NUM_PROG-1:0]  prog_en_o
);
   import cbuf_pkg::*;

   localparam int HI_W = (ADDR_W > DATA_W) ? ADDR_W - DATA_W : 1;

   initial begin
      assert (SIZE_W <= DATA_W) else $error("size register wider than data bus");
      assert (ADDR_W <= 2 * DATA_W) else $error("address needs more than two words");
      assert (NUM_PROG <= DATA_W) else $error("too many program enables");
   end

   logic wr_size, wr_hi, wr_lo, wr_pos, wr_en_cfg;
   assign wr_size   = wr_en && (wr_idx == REG_IDX_W'(IDX_SIZE));
   assign wr_hi     = wr_en && (wr_idx == REG_IDX_W'(IDX_BASE_HI));
   assign wr_lo     = wr_en && (wr_idx == REG_IDX_W'(IDX_BASE_LO));
   assign wr_pos    = wr_en && (wr_idx == REG_IDX_W'(IDX_POS));
   assign wr_en_cfg = wr_en && (wr_idx == REG_IDX_W'(IDX_STAGE_EN));

   logic [DATA_W-1:0]   lo_q;
   logic [SIZE_W-1:0]   size_q;
   logic [SIZE_W-1:0]   pos_q;
   logic [NUM_PROG-1:0] prog_q;

   logic unused_cfg;
   assign unused_cfg = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         size_q <= '0;
         pos_q  <= '0;
         prog_q <= '0;
      end else begin
         if (wr_lo)     lo_q   <= wr_data;
         if (wr_size)   size_q <= wr_data[SIZE_W-1:0];
         if (wr_en_cfg) prog_q <= wr_data[NUM_PROG-1:0];
         if (wr_pos)
            pos_q <= wr_data[SIZE_W-1:0];
         else if (advance)
            pos_q <= pos_q + SIZE_W'(WORD_BYTES);
      end
   end

   generate
      if (ADDR_W > DATA_W) begin : g_split_base
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hi_q <= '0;
            else if (wr_hi) hi_q <= wr_data[HI_W-1:0];
         end
         assign base_o = {hi_q, lo_q};
      end else begin : g_single_base
         logic unused_hi;
         assign unused_hi = wr_hi;
         assign base_o = lo_q[ADDR_W-1:0];
      end
   endgenerate

   assign size_o    = size_q;
   assign pos_o     = pos_q;
   assign prog_en_o = prog_q;

endmodule

// File: rtl/cbuf_stream.sv
module cbuf_stream #(
   parameter int ADDR_W     = 40,
   parameter int DATA_W     = 32,
   parameter int SIZE_W     = 32,
   parameter int REG_IDX_W  = 8,
   parameter int DATA_WIN   = 16,
   parameter int DATA_FIRST = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_IDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    base,
   input  logic [SIZE_W-1:0]    size,
   input  logic [SIZE_W-1:0]    pos,
   output logic                 advance,
   output logic                 mem_wr_valid,
   output logic [ADDR_W-1:0]    mem_wr_addr,
   output logic [DATA_W-1:0]    mem_wr_data,
   output logic                 err_overrun,
   output logic                 err_null_base
);
   import cbuf_pkg::*;

   localparam logic [REG_IDX_W:0] WIN_LO = (REG_IDX_W+1)'(DATA_FIRST);
   localparam logic [REG_IDX_W:0] WIN_HI = (REG_IDX_W+1)'(DATA_FIRST + DATA_WIN);

   initial begin
      assert (ADDR_W >= SIZE_W) else $error("address narrower than position");
      assert (DATA_FIRST + DATA_WIN <= (1 << REG_IDX_W)) else $error("data window outside index space");
      assert (DATA_WIN >= 1) else $error("empty data window");
   end

   logic hit, past_end, null_base;
   logic [SIZE_W:0] end_pos;

   assign hit       = wr_en && ({1'b0, wr_idx} >= WIN_LO) && ({1'b0, wr_idx} < WIN_HI);
   assign end_pos   = {1'b0, pos} + (SIZE_W+1)'(WORD_BYTES);
   assign past_end  = end_pos > {1'b0, size};
   assign null_base = (base == '0);
   assign advance   = hit && !past_end && !null_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_wr_valid  <= 1'b0;
         mem_wr_addr   <= '0;
         mem_wr_data   <= '0;
         err_overrun   <= 1'b0;
         err_null_base <= 1'b0;
      end else begin
         mem_wr_valid  <= advance;
         err_overrun   <= hit && past_end;
         err_null_base <= hit && null_base;
         if (advance) begin
            mem_wr_addr <= base + ADDR_W'(pos);
            mem_wr_data <= wr_data;
         end
      end
   end

endmodule

// File: rtl/cbuf_bind_table.sv
module cbuf_bind_table #(
   parameter int ADDR_W     = 40,
   parameter int DATA_W     = 32,
   parameter int SIZE_W     = 32,
   parameter int REG_IDX_W  = 8,
   parameter int NUM_STAGES = 5,
   parameter int NUM_SLOTS  = 18,
   parameter int IDX_W      = 5,
   parameter int STG_W      = 3,
   parameter int BIND_FIRST = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_IDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    base,
   input  logic [SIZE_W-1:0]    size,
   input  logic [STG_W-1:0]     rd_stage,
   input  logic [IDX_W-1:0]     rd_slot,
   output logic                 err_bad_slot,
   output logic                 rd_enabled,
   output logic [IDX_W-1:0]     rd_index,
   output logic [ADDR_W-1:0]    rd_addr,
   output logic [SIZE_W-1:0]    rd_size
);
   import cbuf_pkg::*;

   initial begin
      assert (NUM_SLOTS <= (1 << IDX_W)) else $error("slot count exceeds index field");
      assert (NUM_STAGES <= (1 << STG_W)) else $error("stage select too narrow");
      assert (BIND_FIRST + NUM_STAGES <= (1 << REG_IDX_W)) else $error("bind registers outside index space");
      assert (BIND_SLOT_LSB + IDX_W <= DATA_W) else $error("slot field outside data word");
   end

   logic [NUM_STAGES-1:0] stage_hit;
   logic [IDX_W-1:0]      sel;
   logic                  sel_ok;
   logic                  bind_valid;

   generate
      for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage_dec
         assign stage_hit[g] = wr_en && (wr_idx == REG_IDX_W'(BIND_FIRST + g));
      end
   endgenerate

   assign sel        = wr_data[BIND_SLOT_LSB +: IDX_W];
   assign bind_valid = wr_data[BIND_VALID_BIT];
   assign sel_ok     = {1'b0, sel} < (IDX_W+1)'(NUM_SLOTS);

   logic unused_bind;
   assign unused_bind = ^wr_data;

   logic              en_q   [NUM_STAGES][NUM_SLOTS];
   logic [IDX_W-1:0]  idx_q  [NUM_STAGES][NUM_SLOTS];
   logic [ADDR_W-1:0] addr_q [NUM_STAGES][NUM_SLOTS];
   logic [SIZE_W-1:0] size_q [NUM_STAGES][NUM_SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_bad_slot <= 1'b0;
         for (int s = 0; s < NUM_STAGES; s++) begin
            for (int j = 0; j < NUM_SLOTS; j++) begin
               en_q[s][j]   <= 1'b0;
               idx_q[s][j]  <= '0;
               addr_q[s][j] <= '0;
               size_q[s][j] <= '0;
            end
         end
      end else begin
         err_bad_slot <= (|stage_hit) && !sel_ok;
         for (int s = 0; s < NUM_STAGES; s++) begin
            for (int j = 0; j < NUM_SLOTS; j++) begin
               if (stage_hit[s] && (sel == IDX_W'(j))) begin
                  en_q[s][j]   <= bind_valid;
                  idx_q[s][j]  <= sel;
                  addr_q[s][j] <= base;
                  size_q[s][j] <= size;
               end
            end
         end
      end
   end

   always_comb begin
      rd_enabled = 1'b0;
      rd_index   = '0;
      rd_addr    = '0;
      rd_size    = '0;
      for (int s = 0; s < NUM_STAGES; s++) begin
         for (int j = 0; j < NUM_SLOTS; j++) begin
            if ((rd_stage == STG_W'(s)) && (rd_slot == IDX_W'(j))) begin
               rd_enabled = en_q[s][j];
               rd_index   = idx_q[s][j];
               rd_addr    = addr_q[s][j];
               rd_size    = size_q[s][j];
            end
         end
      end
   end

endmodule

// File: rtl/cbuf_upload_bind.sv
module cbuf_upload_bind #(
   parameter int ADDR_W     = 40,
   parameter int DATA_W     = 32,
   parameter int SIZE_W     = 32,
   parameter int REG_IDX_W  = 8,
   parameter int NUM_STAGES = 5,
   parameter int NUM_SLOTS  = 18,
   parameter int IDX_W      = 5,
   parameter int STG_W      = 3,
   parameter int DATA_WIN   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_IDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [STG_W-1:0]     rd_stage,
   input  logic [IDX_W-1:0]     rd_slot,
   output logic                 mem_wr_valid,
   output logic [ADDR_W-1:0]    mem_wr_addr,
   output logic [DATA_W-1:0]    mem_wr_data,
   output logic                 err_overrun,
   output logic                 err_null_base,
   output logic                 err_bad_slot,
   output logic                 rd_enabled,
   output logic [IDX_W-1:0]     rd_index,
   output logic [ADDR_W-1:0]    rd_addr,
   output logic [SIZE_W-1:0]    rd_size,
   output logic                 rd_stage_en
);
   import cbuf_pkg::*;

   localparam int NUM_PROG = NUM_STAGES - 1;

   initial begin
      assert (NUM_STAGES >= 2) else $error("need vertex plus at least one programmable stage");
      assert (IDX_DATA_FIRST + DATA_WIN <= IDX_BIND_FIRST) else $error("data window overlaps bind registers");
   end

   logic [ADDR_W-1:0]   base;
   logic [SIZE_W-1:0]   size;
   logic [SIZE_W-1:0]   pos;
   logic [NUM_PROG-1:0] prog_en;
   logic                advance;

   cbuf_cfg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
      .REG_IDX_W(REG_IDX_W), .NUM_PROG(NUM_PROG)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .advance(advance), .base_o(base), .size_o(size), .pos_o(pos), .prog_en_o(prog_en)
   );

   cbuf_stream #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .REG_IDX_W(REG_IDX_W),
      .DATA_WIN(DATA_WIN), .DATA_FIRST(IDX_DATA_FIRST)
   ) i_stream (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .base(base), .size(size), .pos(pos), .advance(advance),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .err_overrun(err_overrun), .err_null_base(err_null_base)
   );

   cbuf_bind_table #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .REG_IDX_W(REG_IDX_W),
      .NUM_STAGES(NUM_STAGES), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .STG_W(STG_W),
      .BIND_FIRST(IDX_BIND_FIRST)
   ) i_table (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .base(base), .size(size), .rd_stage(rd_stage), .rd_slot(rd_slot),
      .err_bad_slot(err_bad_slot), .rd_enabled(rd_enabled), .rd_index(rd_index),
      .rd_addr(rd_addr), .rd_size(rd_size)
   );

   // stage 0 is hard-wired enabled, the rest follow the program enables
   logic [NUM_STAGES-1:0] stage_on;
   assign stage_on = {prog_en, 1'b1};

   always_comb begin
      rd_stage_en = 1'b0;
      for (int s = 0; s < NUM_STAGES; s++) begin
         if (rd_stage == STG_W'(s)) rd_stage_en = stage_on[s];
      end
   end

endmodule

// File: rtl/cbuf_upload_bind_chk.sv
module cbuf_upload_bind_chk #(
   parameter int ADDR_W = 40,
   parameter int SIZE_W = 32,
   parameter int STG_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              mem_wr_valid,
   input logic              err_overrun,
   input logic              err_null_base,
   input logic              err_bad_slot,
   input logic [STG_W-1:0]  rd_stage,
   input logic              rd_stage_en,
   input logic [ADDR_W-1:0] cur_base,
   input logic [SIZE_W-1:0] cur_size,
   input logic [SIZE_W-1:0] cur_pos
);

   // R4 R5: a refused write never also issues a request
   p_refuse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_overrun || err_null_base) |-> !mem_wr_valid);

   // R3: an issued request comes with a one-word advance
   p_pos_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (cur_pos == $past(cur_pos) + SIZE_W'(4)));

   // R4: refused writes leave the position alone
   p_pos_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_overrun || err_null_base) |-> (cur_pos == $past(cur_pos)));

   // R4: a request always fits inside the buffer
   p_req_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (($past(cur_size) >= SIZE_W'(4)) &&
                        ($past(cur_pos) <= $past(cur_size) - SIZE_W'(4))));

   // R5: no request is ever made against a zero base
   p_no_null_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> ($past(cur_base) != '0));

   // R8: the slot error only follows a register write
   p_bad_slot_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_bad_slot |-> $past(wr_en));

   // R10: the vertex stage reads enabled
   p_vertex_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stage == '0) |-> rd_stage_en);

   // R2: requests last one cycle when no write precedes them
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !wr_en) |=> !mem_wr_valid);

endmodule

bind cbuf_upload_bind cbuf_upload_bind_chk #(
   .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .STG_W(STG_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mem_wr_valid(mem_wr_valid),
   .err_overrun(err_overrun), .err_null_base(err_null_base), .err_bad_slot(err_bad_slot),
   .rd_stage(rd_stage), .rd_stage_en(rd_stage_en),
   .cur_base(base), .cur_size(size), .cur_pos(pos)
);

// File: tb/test_cbuf_upload_bind.sv
module test_cbuf_upload_bind;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_stage = '0;
   logic [4:0]  rd_slot = '0;
   logic        mem_wr_valid;
   logic [39:0] mem_wr_addr;
   logic [31:0] mem_wr_data;
   logic        err_overrun, err_null_base, err_bad_slot;
   logic        rd_enabled;
   logic [4:0]  rd_index;
   logic [39:0] rd_addr;
   logic [31:0] rd_size;
   logic        rd_stage_en;

   int n_chk = 0;
   int n_bad = 0;

   logic        c_v, c_ov, c_nb, c_bs;
   logic [39:0] c_a;
   logic [31:0] c_d;

   always #10 clk = ~clk;

   cbuf_upload_bind i_cbuf_upload_bind (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_stage(rd_stage), .rd_slot(rd_slot),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .err_overrun(err_overrun), .err_null_base(err_null_base), .err_bad_slot(err_bad_slot),
      .rd_enabled(rd_enabled), .rd_index(rd_index), .rd_addr(rd_addr), .rd_size(rd_size),
      .rd_stage_en(rd_stage_en)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one register write; captures the outputs registered at its edge
   task automatic wr(input logic [7:0] idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(posedge clk);
      #2;
      c_v = mem_wr_valid; c_a = mem_wr_addr; c_d = mem_wr_data;
      c_ov = err_overrun; c_nb = err_null_base; c_bs = err_bad_slot;
      wr_en = 1'b0;
   endtask

   task automatic set_base(input logic [39:0] b);
      wr(8'h01, {24'h0, b[39:32]});
      wr(8'h02, b[31:0]);
   endtask

   task automatic expect_req(input string req, input logic [39:0] a, input logic [31:0] d);
      check({req, " valid"}, 64'(c_v), 64'd1);
      check({req, " addr"}, 64'(c_a), 64'(a));
      check({req, " data"}, 64'(c_d), 64'(d));
      check({req, " errs"}, 64'({c_ov, c_nb}), 64'd0);
   endtask

   task automatic expect_none(input string req, input logic ov, input logic nb);
      check({req, " valid"}, 64'(c_v), 64'd0);
      check({req, " overrun"}, 64'(c_ov), 64'(ov));
      check({req, " nullbase"}, 64'(c_nb), 64'(nb));
   endtask

   task automatic look(input string req, input int s, input int k, input logic en,
                       input logic [4:0] ix, input logic [39:0] a, input logic [31:0] sz);
      @(negedge clk);
      rd_stage = 3'(s); rd_slot = 5'(k);
      #1;
      check({req, " enabled"}, 64'(rd_enabled), 64'(en));
      check({req, " index"}, 64'(rd_index), 64'(ix));
      check({req, " addr"}, 64'(rd_addr), 64'(a));
      check({req, " size"}, 64'(rd_size), 64'(sz));
   endtask

   function automatic logic [39:0] b_addr(input int s, input int k);
      return {8'(s + 1), 32'(k * 256 + 64)};
   endfunction
   function automatic logic [31:0] b_size(input int s, input int k);
      return 32'(k * 4 + s + 8);
   endfunction
   function automatic logic b_en(input int s, input int k);
      return 1'((s + k) & 1);
   endfunction

   initial begin : watchdog
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [39:0] base;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 valid", 64'(mem_wr_valid), 64'd0);
      check("R1 errs", 64'({err_overrun, err_null_base, err_bad_slot}), 64'd0);
      look("R1 slot", 0, 0, 1'b0, 5'd0, 40'd0, 32'd0);
      look("R1 slot", 4, 17, 1'b0, 5'd0, 40'd0, 32'd0);
      @(negedge clk) rd_stage = 3'd2; #1;
      check("R1 stage disabled", 64'(rd_stage_en), 64'd0);

      // R2 R3 R6: all sixteen window aliases stream into consecutive words
      base = 40'h12_3456_7800;
      set_base(base);
      wr(8'h00, 32'd64);
      wr(8'h03, 32'd0);
      for (int i = 0; i < 16; i++) begin
         wr(8'(16 + i), 32'hC0DE_0000 + 32'(i));
         expect_req("R2 R3 stream", base + 40'(4 * i), 32'hC0DE_0000 + 32'(i));
      end
      @(posedge clk); #2;
      check("R2 one-cycle request", 64'(mem_wr_valid), 64'd0);

      // R4: position 64 with size 64 is past the end
      wr(8'h1F, 32'hDEAD_0001);
      expect_none("R4 past end", 1'b1, 1'b0);
      @(posedge clk); #2;
      check("R4 one-cycle pulse", 64'(err_overrun), 64'd0);
      wr(8'h00, 32'd68);
      wr(8'h10, 32'h0000_1111);
      expect_req("R4 position held", base + 40'd64, 32'h0000_1111);

      // R4 boundary: last word exactly fits, next is refused
      wr(8'h00, 32'd64);
      wr(8'h03, 32'd60);
      wr(8'h15, 32'h0000_2222);
      expect_req("R4 last word", base + 40'd60, 32'h0000_2222);
      wr(8'h15, 32'h0000_3333);
      expect_none("R4 after last", 1'b1, 1'b0);
      wr(8'h00, 32'd0);
      wr(8'h03, 32'd0);
      wr(8'h12, 32'h0000_4444);
      expect_none("R4 zero size", 1'b1, 1'b0);
      wr(8'h00, 32'd2);
      wr(8'h12, 32'h0000_5555);
      expect_none("R4 short size", 1'b1, 1'b0);

      // R5: zero base refused, position kept
      wr(8'h00, 32'd64);
      set_base(40'd0);
      wr(8'h13, 32'h0000_6666);
      expect_none("R5 null base", 1'b0, 1'b1);
      wr(8'h02, 32'h0000_0100);
      wr(8'h13, 32'h0000_7777);
      expect_req("R5 position held", 40'h00_0000_0100, 32'h0000_7777);
      // R6: high byte alone makes a nonzero base
      set_base(40'h01_0000_0000);
      wr(8'h14, 32'h0000_8888);
      expect_req("R6 high base", 40'h01_0000_0004, 32'h0000_8888);

      // R11: unused indices do nothing
      wr(8'h08, 32'hFFFF_FFFF);
      expect_none("R11 unused idx", 1'b0, 1'b0);
      check("R11 no slot err", 64'(c_bs), 64'd0);
      wr(8'h25, 32'h0000_0011);
      check("R11 past bind regs", 64'(c_bs), 64'd0);
      wr(8'h17, 32'h0000_9999);
      expect_req("R11 stream intact", 40'h01_0000_0008, 32'h0000_9999);

      // R7 R8: every stage, every index
      for (int s = 0; s < 5; s++) begin
         for (int k = 0; k < 32; k++) begin
            set_base(b_addr(s, k));
            wr(8'h00, b_size(s, k));
            wr(8'(32 + s), (32'(k) << 4) | 32'(b_en(s, k)));
            if (k < 18) begin
               check("R7 no slot err", 64'(c_bs), 64'd0);
               look("R7 bind", s, k, b_en(s, k), 5'(k), b_addr(s, k), b_size(s, k));
            end else begin
               check("R8 slot err", 64'(c_bs), 64'd1);
               look("R8 ignored", s, k - 18, b_en(s, k - 18), 5'(k - 18),
                    b_addr(s, k - 18), b_size(s, k - 18));
            end
         end
      end
      // R7: snapshots unaffected by later base/size changes
      set_base(40'hFF_FFFF_FFFC);
      wr(8'h00, 32'd4);
      for (int s = 0; s < 5; s++)
         for (int k = 0; k < 18; k += 5)
            look("R7 snapshot", s, k, b_en(s, k), 5'(k), b_addr(s, k), b_size(s, k));

      // R9: out-of-range reads are zero
      for (int s = 5; s < 8; s++) look("R9 bad stage", s, 3, 1'b0, 5'd0, 40'd0, 32'd0);
      for (int k = 18; k < 32; k += 6) look("R9 bad slot", 1, k, 1'b0, 5'd0, 40'd0, 32'd0);

      // R10: all enable patterns
      for (int p = 0; p < 16; p++) begin
         wr(8'h04, 32'(p));
         for (int s = 0; s < 8; s++) begin
            @(negedge clk) rd_stage = 3'(s);
            #1;
            check("R10 stage enable", 64'(rd_stage_en),
                  64'((s == 0) ? 1 : (s < 5) ? ((p >> (s - 1)) & 1) : 0));
         end
      end

      // R1: a second reset clears the table
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      look("R1 cleared", 3, 7, 1'b0, 5'd0, 40'd0, 32'd0);
      @(negedge clk) rd_stage = 3'd4; #1;
      check("R1 enables cleared", 64'(rd_stage_en), 64'd0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule